// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Parking and Ownership Timer

This block is the central arbiter of a shared parallel bus. Five agents compete for it: four add-in slots and one graphics-port agent. Each agent raises its own active-low request line. The arbiter answers on exactly one matching active-low grant line. A new owner is chosen only while the bus is idle, meaning both the frame and initiator-ready lines are high. Among the competing agents, the choice follows a rotating order, so that no agent is starved.

Once an agent holds the grant, it keeps it in two cases. The first is while nobody else is asking for the bus (parking). The second is while a programmable ownership timer is still running and the owner keeps requesting. Parking does not apply to the agent that acts as the bridge toward the legacy expansion bus: when its request goes away, the grant is dropped and the bus stays unowned. A strap input removes the fourth slot pair from arbitration in systems that do not fit that slot. A change of owner always leaves one clock in which no grant is active.

All pins are plain control levels sampled on the rising clock edge. There is no data stream and no handshake. The grant pins come directly from registers.

Top module: `pci_rr_arbiter`

## Requirements
- R1: While reset is asserted, and on the first clock after it, all grant lines are high.
- R2: At most one grant line is low in any clock.
- R3: When no grant is active, a grant is asserted on the clock after a cycle in which the bus is idle (frame high and initiator-ready high) and at least one enabled request is low; no grant is asserted from a cycle in which the bus is busy.
- R4: The winner is the first enabled requester found searching upward from the rotation pointer, wrapping from agent 4 to agent 0; after a grant to agent k, the pointer becomes k+1 (modulo 5); after reset it is 0.
- R5: An owner other than the bridge (agent 0) keeps its grant while no other enabled agent requests, even after its own request goes high.
- R6: When the bridge (agent 0) owns the bus, its request is high and no other enabled agent requests, its grant is removed on the next clock.
- R7: Going from one owner to another always passes through at least one clock with all grants high.
- R8: On each new grant the ownership timer loads the value of mtt_limit. It counts down once per clock while the grant is held. While it is nonzero and the owner still requests, other requests do not take the grant away.
- R9: An owner loses its grant to other requesters only at the end of a cycle in which the bus is idle and either the timer is zero or the owner no longer requests.
- R10: When slot4_en is low, the request of agent 3 is ignored: it never causes a grant and never counts as a competing request.
- R11: A grant line only falls if its own request was low in the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 5 | Active-low request, one bit per agent (bit 0 = bridge, bit 4 = graphics port) |
| frame_n | input | 1 | Active-low bus frame line |
| irdy_n | input | 1 | Active-low initiator-ready line |
| slot4_en | input | 1 | Strap; high enables request/grant pair 3 |
| mtt_limit | input | 8 | Ownership timer reload value in clocks |
| gnt_n | output | 5 | Active-low grant, one bit per agent |

## Verification
The assertions assume that every input carries a known level at each rising edge. The parking check also assumes that the strap does not disable the current owner's pair in the same cycle it is evaluated. The stimulus meets both conditions. It changes inputs only at a fixed offset after the rising edge and always drives defined values. It leaves the strap unchanged for long runs. Directed phases place the bus busy or idle deliberately around owner changes. A long mixed phase then draws requests, bus activity and timer reloads freely, so that parking, preemption and masking meet in many orders.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;
  localparam int AGENTS_DEF = 5;
  localparam int TIMER_W_DEF = 8;

  typedef enum logic {
    ARB_FREE  = 1'b0,
    ARB_OWNED = 1'b1
  } arb_state_e;
endpackage

// File: rtl/pci_arb_mask.sv
module pci_arb_mask #(
  parameter int N       = 5,
  parameter int MASK_ID = 3
) (
  input  logic [N-1:0] req_n,
  input  logic         slot_en,
  output logic [N-1:0] en,
  output logic [N-1:0] req
);
  for (genvar i = 0; i < N; i++) begin : g_line
    if (i == MASK_ID) begin : g_strap
      assign en[i] = slot_en;
    end else begin : g_fixed
      assign en[i] = 1'b1;
    end
    assign req[i] = ~req_n[i] & en[i];
  end
endmodule

// File: rtl/pci_arb_pick.sv
module pci_arb_pick #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] ptr,
  output logic             vld,
  output logic [IDX_W-1:0] win
);
  int idx;
  always_comb begin
    vld = 1'b0;
    win = '0;
    idx = 0;
    // Search from the far end so the nearest requester is written last.
    for (int k = N - 1; k >= 0; k--) begin
      idx = (int'(ptr) + k) % N;
      if (req[idx]) begin
        vld = 1'b1;
        win = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/pci_arb_mtt.sv
module pci_arb_mtt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         busy
);
  logic [W-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign busy = (cnt != '0);
endmodule

// File: rtl/pci_rr_arbiter.sv
module pci_rr_arbiter #(
  parameter int N_AGENTS  = pci_arb_pkg::AGENTS_DEF,
  parameter int BRIDGE_ID = 0,
  parameter int MASK_ID   = 3,
  parameter int TIMER_W   = pci_arb_pkg::TIMER_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] req_n,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic                slot4_en,
  input  logic [TIMER_W-1:0]  mtt_limit,
  output logic [N_AGENTS-1:0] gnt_n
);
  import pci_arb_pkg::*;
  localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

  arb_state_e          state;
  logic [IDX_W-1:0]    owner, ptr, win;
  logic                win_vld, tmr_busy;
  logic [N_AGENTS-1:0] en, req, owner_oh;
  logic                idle, others, own_req, own_en, do_grant, do_release;

  pci_arb_mask #(.N(N_AGENTS), .MASK_ID(MASK_ID)) u_mask (
    .req_n(req_n), .slot_en(slot4_en), .en(en), .req(req)
  );

  pci_arb_pick #(.N(N_AGENTS), .IDX_W(IDX_W)) u_pick (
    .req(req), .ptr(ptr), .vld(win_vld), .win(win)
  );

  pci_arb_mtt #(.W(TIMER_W)) u_mtt (
    .clk(clk), .rst_n(rst_n), .load(do_grant), .load_val(mtt_limit),
    .run(state == ARB_OWNED && !do_release), .busy(tmr_busy)
  );

  assign owner_oh = (state == ARB_OWNED) ? (N_AGENTS'(1) << owner) : '0;
  assign idle     = frame_n & irdy_n;
  assign others   = |(req & ~owner_oh);
  assign own_req  = |(req & owner_oh);
  assign own_en   = |(en & owner_oh);
  assign do_grant = (state == ARB_FREE) && idle && win_vld;

  always_comb begin
    do_release = 1'b0;
    if (state == ARB_OWNED) begin
      if (others)
        do_release = idle && (!tmr_busy || !own_req);
      else
        do_release = !(own_req || (owner != IDX_W'(BRIDGE_ID) && own_en));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ARB_FREE;
      owner <= '0;
      ptr   <= '0;
    end else if (do_grant) begin
      state <= ARB_OWNED;
      owner <= win;
      ptr   <= (win == IDX_W'(N_AGENTS - 1)) ? '0 : win + 1'b1;
    end else if (do_release) begin
      state <= ARB_FREE;
    end
  end

  assign gnt_n = ~owner_oh;
endmodule

// File: rtl/pci_arb_checker.sv
module pci_arb_checker #(
  parameter int N         = 5,
  parameter int BRIDGE_ID = 0,
  parameter int MASK_ID   = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_n,
  input logic         frame_n,
  input logic         irdy_n,
  input logic         slot4_en,
  input logic [N-1:0] gnt_n
);
  logic [N-1:0] en_v;
  logic         other_req;
  for (genvar i = 0; i < N; i++) begin : g_en
    assign en_v[i] = (i == MASK_ID) ? slot4_en : 1'b1;
  end
  assign other_req = |(~req_n & gnt_n & en_v);

  a_r1_reset_no_grant: assert property (@(posedge clk) !rst_n |-> &gnt_n);

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~gnt_n) <= 1);

  a_r7_gap_between_owners: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&$past(gnt_n)) && !(&gnt_n)) |-> gnt_n == $past(gnt_n));

  a_r3_grant_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((&$past(gnt_n)) && !(&gnt_n)) |-> $past(frame_n && irdy_n));

  a_r5_parked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(&gnt_n) && gnt_n[BRIDGE_ID] && !other_req && (&(gnt_n | en_v)))
      |-> gnt_n == $past(gnt_n));

  a_r6_bridge_unparked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!gnt_n[BRIDGE_ID] && req_n[BRIDGE_ID] && !other_req) |-> gnt_n[BRIDGE_ID]);

  a_r10_masked_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnt_n[MASK_ID]) |-> $past(slot4_en));

  for (genvar i = 0; i < N; i++) begin : g_req
    a_r11_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gnt_n[i]) |-> $past(!req_n[i]));
  end
endmodule

bind pci_rr_arbiter pci_arb_checker #(
  .N(N_AGENTS), .BRIDGE_ID(BRIDGE_ID), .MASK_ID(MASK_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
  .irdy_n(irdy_n), .slot4_en(slot4_en), .gnt_n(gnt_n)
);

// File: tb/pci_rr_arbiter_bench.sv
`timescale 1ns/1ps
module pci_rr_arbiter_bench;
  localparam int NA = 5;
  localparam int BR = 0;
  localparam int MK = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NA-1:0] req_n = '1;
  logic          frame_n = 1'b1, irdy_n = 1'b1, slot4_en = 1'b1;
  logic [7:0]    mtt_limit = 8'd0;
  logic [NA-1:0] gnt_n;

  int    n_cmp = 0, n_bad = 0;
  int    m_owner = -1, m_ptr = 0, m_tmr = 0;
  bit    running = 1'b0;
  string phase = "R1 reset";
  logic [NA-1:0] prev_gnt = '1;

  always #2.5 clk = ~clk;

  pci_rr_arbiter u_pci_rr_arbiter (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .slot4_en(slot4_en), .mtt_limit(mtt_limit), .gnt_n(gnt_n)
  );

  function automatic bit wants(int a);
    return !req_n[a] && !(a == MK && !slot4_en);
  endfunction

  // Behavioural reference: who owns the bus after this edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_owner = -1; m_ptr = 0; m_tmr = 0;
    end else begin
      bit idle, rivals, mine, allowed;
      idle = frame_n && irdy_n;
      if (m_owner < 0) begin
        if (idle) begin
          for (int k = 0; k < NA; k++) begin
            if (m_owner < 0 && wants((m_ptr + k) % NA)) m_owner = (m_ptr + k) % NA;
          end
          if (m_owner >= 0) begin
            m_ptr = (m_owner + 1) % NA;
            m_tmr = mtt_limit;
          end
        end
      end else begin
        rivals = 1'b0;
        for (int a = 0; a < NA; a++) if (a != m_owner && wants(a)) rivals = 1'b1;
        mine = wants(m_owner);
        allowed = !(m_owner == MK && !slot4_en);
        if (rivals && idle && (m_tmr == 0 || !mine)) m_owner = -1;
        else if (!rivals && !mine && (m_owner == BR || !allowed)) m_owner = -1;
        else if (m_tmr > 0) m_tmr--;
      end
    end
  end

  task automatic check(bit ok, string tag, logic [NA-1:0] act, logic [NA-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: gnt_n actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      logic [NA-1:0] exp;
      exp = (m_owner < 0) ? '1 : ~(NA'(1) << m_owner);
      check(gnt_n === exp, phase, gnt_n, exp);
      // R2 at most one grant
      check($countones(~gnt_n) <= 1, "R2 one grant", gnt_n, exp);
      // R7 no direct hand-over between owners
      check((&prev_gnt) || (&gnt_n) || gnt_n == prev_gnt, "R7 gap", gnt_n, prev_gnt);
      prev_gnt = gnt_n;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(logic [NA-1:0] r, logic f, logic i);
    req_n = r; frame_n = f; irdy_n = i;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    running = 1'b1;
    step(3);
    check(&gnt_n, "R1 reset", gnt_n, '1);
    rst_n = 1'b1;
    step(1);
    check(&gnt_n, "R1 after reset", gnt_n, '1);

    phase = "R3 busy then idle";
    drive(5'b11101, 1'b0, 1'b1);
    step(4);
    check(&gnt_n, "R3 no grant while busy", gnt_n, '1);
    drive(5'b11101, 1'b1, 1'b1);
    step(2);
    check(gnt_n == 5'b11101, "R3 grant on idle", gnt_n, 5'b11101);

    phase = "R4 rotation";
    drive(5'b00000, 1'b1, 1'b1);
    step(30);

    phase = "R9 hold while busy";
    drive(5'b00000, 1'b0, 1'b0);
    step(3);
    begin
      logic [NA-1:0] held;
      held = gnt_n;
      step(6);
      check(gnt_n == held, "R9 owner kept while bus busy", gnt_n, held);
    end

    phase = "R5 parking";
    drive(5'b11111, 1'b1, 1'b1);
    step(3);
    drive(5'b11011, 1'b1, 1'b1);
    step(4);
    drive(5'b11111, 1'b1, 1'b1);
    step(5);
    check(gnt_n == 5'b11011, "R5 parked on agent 2", gnt_n, 5'b11011);

    phase = "R6 bridge";
    drive(5'b11110, 1'b1, 1'b1);
    step(6);
    drive(5'b11111, 1'b1, 1'b1);
    step(3);
    check(&gnt_n, "R6 bridge not parked", gnt_n, '1);

    phase = "R8 timer hold";
    mtt_limit = 8'd6;
    drive(5'b11101, 1'b1, 1'b1);
    step(3);
    drive(5'b11001, 1'b1, 1'b1);
    step(3);
    check(gnt_n == 5'b11101, "R8 owner kept while timer runs", gnt_n, 5'b11101);
    step(10);
    mtt_limit = 8'd0;

    phase = "R10 strap off";
    slot4_en = 1'b0;
    drive(5'b11111, 1'b1, 1'b1);
    step(4);
    drive(5'b10111, 1'b1, 1'b1);
    step(5);
    check(&gnt_n, "R10 masked request ignored", gnt_n, '1);
    drive(5'b00111, 1'b1, 1'b1);
    step(12);
    slot4_en = 1'b1;

    phase = "R4 R8 R9 mixed";
    for (int c = 0; c < 4000; c++) begin
      req_n   = NA'($urandom);
      frame_n = ($urandom % 4) != 0;
      irdy_n  = ($urandom % 3) != 0;
      if (c % 16 == 0) mtt_limit = 8'($urandom % 8);
      if (c % 500 == 250) slot4_en = ~slot4_en;
      step(1);
    end

    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule